// File: doc/BRIEF.md
# Next-Address Microcode Sequencer

This block steps a microcoded processor through its control store without any microprogram counter. The control store holds 512 words of 40 bits, built from five parallel 8-bit slices. The register that holds the current microaddress is reloaded on every clock. The word at that address is presented on the control output. Its two selector bits and its 9-bit successor field decide where the next cycle goes. The next address can be the named successor, a two-way branch on an external condition, the instruction-fetch entry, or the dispatch entry for the 8-bit opcode.

Dispatch entries occupy the lower half of the store, one word per opcode. The fetch entry and the continuation routines live in the upper half. The top address, 0x1FF, is reserved for hardware. When an interrupt is pending at an instruction boundary, the sequencer goes to 0x1FF instead of the fetch entry. While it sits there, a word fixed by a parameter is driven out in place of the stored one, so the store location is never used as code. A write port loads the store one full word at a time.

Top module: `useq_top`

## Requirements
- R1: While `rst` is high, and on the first clock after it falls, `uaddr` is 0x100 (the fetch entry), and `ctrl_word` shows the stored word at that address.
- R2: `ctrl_word` is the full 40-bit word held at `uaddr`. A write with `ld_en` high replaces all 40 bits at `ld_addr` on the clock edge.
- R3: When bits [10:9] of the current word are 2'b10 (dispatch), the next `uaddr` is {1'b0, `opcode`}.
- R4: When bits [10:9] are 2'b00 (successor), the next `uaddr` is bits [8:0] of the current word.
- R5: When bits [10:9] are 2'b11 (branch), the next `uaddr` is bits [8:1] of the current word with `cond` as bit 0.
- R6: When bits [10:9] are 2'b01 (fetch), the next `uaddr` is 0x100 if `irq` is low and 0x1FF if `irq` is high.
- R7: `irq` has no effect on the next address under the successor, branch and dispatch selections.
- R8: While `uaddr` is 0x1FF, `ctrl_word` equals the TRAP_WORD parameter (default: successor selection to 0x1F0). Writes to address 0x1FF are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 8 | Opcode of the current instruction, used at dispatch |
| cond | input | 1 | Branch condition from the datapath |
| irq | input | 1 | Pending interrupt, sampled at the fetch selection |
| ld_en | input | 1 | Control-store write enable |
| ld_addr | input | 9 | Control-store write address |
| ld_data | input | 40 | Control-store write data |
| uaddr | output | 9 | Current microaddress |
| ctrl_word | output | 40 | Control word for the current microaddress |

## Verification
The hardest case to reach is the reserved address. The stored word there has to be shown to be ignored, and an interrupt has to be shown to act at an instruction boundary and nowhere else. To reach it, the bench writes a misleading word to 0x1FF and then drives `irq` high during dispatch, where it must have no effect. It then raises `irq` again at a fetch word and checks that the hardware word, not the stored one, steers the next cycle. It also raises `irq` a second time at the end of the trap routine to show that the redirect happens again there.

// File: rtl/useq_pkg.sv
package useq_pkg;
   typedef enum logic [1:0] {
      SEL_NEXT     = 2'b00,
      SEL_FETCH    = 2'b01,
      SEL_DISPATCH = 2'b10,
      SEL_BRANCH   = 2'b11
   } nxt_sel_e;

   localparam int SEL_LO = 9;
   localparam int SEL_HI = 10;
endpackage

// File: rtl/useq_store.sv
module useq_store #(
   parameter int AW      = 9,
   parameter int NSLICE  = 5,
   parameter int SLICE_W = 8,
   parameter logic [AW-1:0] LOCK_ADDR = '1
) (
   input  logic                      clk,
   input  logic                      wr_en,
   input  logic [AW-1:0]             wr_addr,
   input  logic [NSLICE*SLICE_W-1:0] wr_data,
   input  logic [AW-1:0]             rd_addr,
   output logic [NSLICE*SLICE_W-1:0] rd_data
);
   localparam int DEPTH = 1 << AW;

   initial begin
      if (NSLICE < 1) $error("useq_store: NSLICE must be at least 1");
      if (SLICE_W < 1) $error("useq_store: SLICE_W must be at least 1");
   end

   logic wr_ok;
   assign wr_ok = wr_en && (wr_addr != LOCK_ADDR);

   for (genvar s = 0; s < NSLICE; s++) begin : g_slice
      logic [SLICE_W-1:0] mem [DEPTH];

      always_ff @(posedge clk) begin
         if (wr_ok) mem[wr_addr] <= wr_data[s*SLICE_W +: SLICE_W];
      end

      assign rd_data[s*SLICE_W +: SLICE_W] = mem[rd_addr];
   end
endmodule

// File: rtl/useq_next.sv
module useq_next
   import useq_pkg::*;
#(
   parameter int AW  = 9,
   parameter int OPW = 8,
   parameter logic [AW-1:0] FETCH_ADDR = 9'h100,
   parameter logic [AW-1:0] TRAP_ADDR  = 9'h1FF
) (
   input  nxt_sel_e         sel,
   input  logic [AW-1:0]    nfield,
   input  logic [OPW-1:0]   opcode,
   input  logic             cond,
   input  logic             irq,
   output logic [AW-1:0]    next_addr
);
   localparam int PAD = AW - OPW;

   initial begin
      if (PAD < 1) $error("useq_next: AW must exceed OPW");
   end

   logic [AW-1:0] disp_addr;
   assign disp_addr = {{PAD{1'b0}}, opcode};

   always_comb begin
      unique case (sel)
         SEL_NEXT:     next_addr = nfield;
         SEL_BRANCH:   next_addr = {nfield[AW-1:1], cond};
         SEL_DISPATCH: next_addr = disp_addr;
         SEL_FETCH:    next_addr = irq ? TRAP_ADDR : FETCH_ADDR;
         default:      next_addr = FETCH_ADDR;
      endcase
   end
endmodule

// File: rtl/useq_top.sv
module useq_top
   import useq_pkg::*;
#(
   parameter int AW      = 9,
   parameter int OPW     = 8,
   parameter int NSLICE  = 5,
   parameter int SLICE_W = 8,
   parameter logic [AW-1:0] FETCH_ADDR = 9'h100,
   parameter logic [NSLICE*SLICE_W-1:0] TRAP_WORD = 40'h00_0000_01F0
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic [OPW-1:0]            opcode,
   input  logic                      cond,
   input  logic                      irq,
   input  logic                      ld_en,
   input  logic [AW-1:0]             ld_addr,
   input  logic [NSLICE*SLICE_W-1:0] ld_data,
   output logic [AW-1:0]             uaddr,
   output logic [NSLICE*SLICE_W-1:0] ctrl_word
);
   localparam int CW = NSLICE * SLICE_W;
   localparam logic [AW-1:0] TRAP_ADDR = '1;

   initial begin
      if (CW < SEL_HI + 1) $error("useq_top: control word too narrow");
      if (AW != SEL_LO) $error("useq_top: successor field must fill bits below selector");
      if (FETCH_ADDR == TRAP_ADDR) $error("useq_top: fetch entry collides with trap address");
   end

   logic [CW-1:0] store_q;
   logic [AW-1:0] uaddr_q;
   logic [AW-1:0] next_addr;
   nxt_sel_e      sel;

   useq_store #(
      .AW(AW), .NSLICE(NSLICE), .SLICE_W(SLICE_W), .LOCK_ADDR(TRAP_ADDR)
   ) u_store (
      .clk(clk), .wr_en(ld_en), .wr_addr(ld_addr), .wr_data(ld_data),
      .rd_addr(uaddr_q), .rd_data(store_q)
   );

   assign ctrl_word = (uaddr_q == TRAP_ADDR) ? TRAP_WORD : store_q;
   assign sel       = nxt_sel_e'(ctrl_word[SEL_HI:SEL_LO]);

   useq_next #(
      .AW(AW), .OPW(OPW), .FETCH_ADDR(FETCH_ADDR), .TRAP_ADDR(TRAP_ADDR)
   ) u_next (
      .sel(sel), .nfield(ctrl_word[AW-1:0]), .opcode(opcode),
      .cond(cond), .irq(irq), .next_addr(next_addr)
   );

   always_ff @(posedge clk) begin
      if (rst) uaddr_q <= FETCH_ADDR;
      else     uaddr_q <= next_addr;
   end

   assign uaddr = uaddr_q;

   p_dispatch_r3: assert property (@(posedge clk) disable iff (rst)
      (ctrl_word[SEL_HI:SEL_LO] == 2'b10) |=> (uaddr == {{(AW-OPW){1'b0}}, $past(opcode)}));
   p_successor_r4: assert property (@(posedge clk) disable iff (rst)
      (ctrl_word[SEL_HI:SEL_LO] == 2'b00) |=> (uaddr == $past(ctrl_word[AW-1:0])));
   p_branch_r5: assert property (@(posedge clk) disable iff (rst)
      (ctrl_word[SEL_HI:SEL_LO] == 2'b11) |=> (uaddr == {$past(ctrl_word[AW-1:1]), $past(cond)}));
   p_fetch_r6: assert property (@(posedge clk) disable iff (rst)
      (ctrl_word[SEL_HI:SEL_LO] == 2'b01 && !irq) |=> (uaddr == FETCH_ADDR));
   p_trap_r6: assert property (@(posedge clk) disable iff (rst)
      (ctrl_word[SEL_HI:SEL_LO] == 2'b01 && irq) |=> (uaddr == TRAP_ADDR));
   p_trap_only_at_fetch_r7: assert property (@(posedge clk) disable iff (rst)
      (ctrl_word[SEL_HI:SEL_LO] != 2'b01 && ctrl_word[AW-1:0] != TRAP_ADDR
       && ctrl_word[SEL_HI:SEL_LO] != 2'b10) |=> (uaddr != TRAP_ADDR));
endmodule

// File: tb/useq_top_bench.sv
`timescale 1ns/1ps
module useq_top_bench;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [7:0]  opcode = '0;
   logic        cond = 1'b0;
   logic        irq = 1'b0;
   logic        ld_en = 1'b0;
   logic [8:0]  ld_addr = '0;
   logic [39:0] ld_data = '0;
   logic [8:0]  uaddr;
   logic [39:0] ctrl_word;

   localparam logic [39:0] TRAP_W = 40'h00_0000_01F0;

   always #10 clk = ~clk;

   useq_top u_useq_top (
      .clk(clk), .rst(rst), .opcode(opcode), .cond(cond), .irq(irq),
      .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
      .uaddr(uaddr), .ctrl_word(ctrl_word)
   );

   int n_run = 0;
   int n_fail = 0;
   bit done = 0;

   function automatic logic [39:0] mkw(input logic [8:0] a, input logic [1:0] s,
                                       input logic [8:0] nx);
      return {20'hC0DE5, a, s, nx};
   endfunction

   // Bench's own copy of the microprogram it loads (stimulus).
   function automatic logic [39:0] prog(input logic [8:0] a);
      case (a)
         9'h100: return mkw(a, 2'b10, 9'h000);
         9'h005: return mkw(a, 2'b00, 9'h120);
         9'h120: return mkw(a, 2'b11, 9'h130);
         9'h130: return mkw(a, 2'b01, 9'h000);
         9'h131: return mkw(a, 2'b00, 9'h140);
         9'h140: return mkw(a, 2'b01, 9'h000);
         9'h0FF: return mkw(a, 2'b01, 9'h000);
         9'h000: return mkw(a, 2'b00, 9'h1FE);
         9'h1FE: return mkw(a, 2'b01, 9'h000);
         9'h1F0: return mkw(a, 2'b01, 9'h000);
         9'h1FF: return mkw(a, 2'b00, 9'h055);
         default: return 40'h0;
      endcase
   endfunction

   localparam int NLOAD = 11;
   localparam logic [8:0] LOADS [NLOAD] = '{
      9'h100, 9'h005, 9'h120, 9'h130, 9'h131, 9'h140,
      9'h0FF, 9'h000, 9'h1FE, 9'h1F0, 9'h1FF};

   // {opcode, cond, irq, expected uaddr after the edge}
   localparam int NVEC = 18;
   localparam logic [18:0] VEC [NVEC] = '{
      {8'h05, 1'b0, 1'b0, 9'h005},
      {8'h00, 1'b0, 1'b1, 9'h120},
      {8'h00, 1'b1, 1'b1, 9'h131},
      {8'h00, 1'b0, 1'b1, 9'h140},
      {8'h00, 1'b0, 1'b0, 9'h100},
      {8'hFF, 1'b0, 1'b1, 9'h0FF},
      {8'h00, 1'b0, 1'b0, 9'h100},
      {8'h00, 1'b0, 1'b0, 9'h000},
      {8'h00, 1'b0, 1'b0, 9'h1FE},
      {8'h00, 1'b0, 1'b0, 9'h100},
      {8'h05, 1'b1, 1'b0, 9'h005},
      {8'h00, 1'b0, 1'b0, 9'h120},
      {8'h00, 1'b0, 1'b0, 9'h130},
      {8'h00, 1'b0, 1'b1, 9'h1FF},
      {8'h00, 1'b0, 1'b1, 9'h1F0},
      {8'h00, 1'b0, 1'b1, 9'h1FF},
      {8'h00, 1'b0, 1'b0, 9'h1F0},
      {8'h00, 1'b0, 1'b0, 9'h100}};

   task automatic chk_addr(input string req, input logic [8:0] exp);
      n_run++;
      if (uaddr !== exp) begin
         n_fail++;
         $display("FAIL %s uaddr actual=%h expected=%h", req, uaddr, exp);
      end
   endtask

   task automatic chk_word(input string req, input logic [39:0] exp);
      n_run++;
      if (ctrl_word !== exp) begin
         n_fail++;
         $display("FAIL %s ctrl_word actual=%h expected=%h", req, ctrl_word, exp);
      end
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      // Load the store while held in reset (R2, R8 stored word at 0x1FF is a decoy).
      for (int i = 0; i < NLOAD; i++) begin
         @(negedge clk);
         ld_en = 1'b1; ld_addr = LOADS[i]; ld_data = prog(LOADS[i]);
      end
      @(negedge clk);
      ld_en = 1'b0;
      @(negedge clk);
      chk_addr("R1", 9'h100);
      chk_word("R2", prog(9'h100));
      rst = 1'b0;

      // Vector walk covering R3..R8.
      for (int v = 0; v < NVEC; v++) begin
         opcode = VEC[v][18:11];
         cond   = VEC[v][10];
         irq    = VEC[v][9];
         @(negedge clk);
         chk_addr($sformatf("R3-R8 vec%0d", v), VEC[v][8:0]);
         chk_word((VEC[v][8:0] == 9'h1FF) ? "R8" : "R2",
                  (VEC[v][8:0] == 9'h1FF) ? TRAP_W : prog(VEC[v][8:0]));
      end

      // R1: reset mid-routine returns to fetch entry.
      opcode = 8'h05; irq = 1'b0; cond = 1'b0;
      @(negedge clk);
      chk_addr("R3", 9'h005);
      rst = 1'b1;
      @(negedge clk);
      chk_addr("R1", 9'h100);
      rst = 1'b0;
      @(negedge clk);
      chk_addr("R1 first cycle after reset dispatch", 9'h005);

      // R2: rewrite a live word, then follow the new successor.
      ld_en = 1'b1; ld_addr = 9'h120; ld_data = mkw(9'h120, 2'b00, 9'h1FE);
      @(negedge clk);
      ld_en = 1'b0;
      chk_addr("R4", 9'h120);
      chk_word("R2", mkw(9'h120, 2'b00, 9'h1FE));
      @(negedge clk);
      chk_addr("R2", 9'h1FE);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule